// File: doc/BRIEF.md
# Pixel Transparency Write-Mask Unit

This block sits after the raster-combine stage of a drawing engine. For every pixel it receives, it gets the source pixel, the destination pixel read back from the frame buffer and the combined result, and it decides whether that result may be written. The decision lets a rectangular sprite be drawn so that only the object lands on the screen and its surrounding background leaves the existing picture untouched.

A 2-bit transparency mode and a key color are held in two internal registers loaded through a small write port. The mode picks one of four tests: always write, hide pixels whose result is zero, hide pixels whose source equals the key, or hide pixels whose destination equals the key. Pixels move through one register stage under valid/ready flow control. A hidden pixel still leaves as a valid beat with its write enable low, so the downstream address counter stays in step.

Two named states control the stage. In `SLOT_EMPTY` no pixel is held. Accepting a pixel takes it to `SLOT_FULL`. In `SLOT_FULL` a pixel is offered downstream. The transitions out of `SLOT_FULL` are:
- fill-while-drain: it stays in `SLOT_FULL` when a new pixel is accepted.
- stall: it stays in `SLOT_FULL` when `out_ready` is low.
- drain: it returns to `SLOT_EMPTY` when the pixel leaves and no new pixel arrives.

Top module: `pxkey_mask_unit`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, the mode is "none" (code 00) and the key color is 0.
- R2: In mode 00 (none), every accepted pixel produces `out_we` = 1, whatever its values.
- R3: In mode 01 (result zero), an accepted pixel whose `in_res` is all zeros produces `out_we` = 0. Any other pixel produces `out_we` = 1.
- R4: In mode 10 (source key), an accepted pixel whose `in_src` equals the key color produces `out_we` = 0. Any other pixel produces `out_we` = 1.
- R5: In mode 11 (destination key), an accepted pixel whose `in_dst` equals the key color produces `out_we` = 0. Any other pixel produces `out_we` = 1.
- R6: A pixel accepted at a clock edge appears at that edge with `out_valid` = 1 and `out_data` equal to its `in_res`.
- R7: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_we` hold their values.
- R8: A suppressed pixel still produces one output beat with `out_valid` = 1 and `out_we` = 0.
- R9: A register write takes effect for pixels accepted at later edges. A pixel accepted at the same edge as the write uses the previous setting.
- R10: A write with `cfg_sel` = 0 loads the key color from `cfg_wdata`. A write with `cfg_sel` = 1 loads the mode from `cfg_wdata[1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 key color, 1 mode |
| cfg_wdata | input | PIX_W | Register write data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high together with in_valid |
| in_src | input | PIX_W | Source pixel |
| in_dst | input | PIX_W | Destination pixel read back |
| in_res | input | PIX_W | Result of the combining operation |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream can take the beat |
| out_data | output | PIX_W | Pixel data to write |
| out_we | output | 1 | Write enable for this pixel |

## Verification
Each verdict and its data are due at the clock edge that accepts the pixel. The bench therefore drives a pixel at a falling edge and reads `out_valid`, `out_we` and `out_data` at the next falling edge. This sample point lies half a period after the register stage has loaded.

A register write lands at its own edge. The bench puts a mode write and a pixel at the same falling edge, expects the old verdict for that pixel, and expects the new verdict one pixel later.

For backpressure, the bench holds `out_ready` low for several cycles. It reads the held beat and `in_ready` at each falling edge, then releases `out_ready`. It then expects the queued pixel one edge after the release.

// File: rtl/pxkey_pkg.sv
package pxkey_pkg;

    typedef enum logic [1:0] {
        KEY_NONE     = 2'b00,
        KEY_RES_ZERO = 2'b01,
        KEY_SRC      = 2'b10,
        KEY_DST      = 2'b11
    } key_mode_e;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;

    localparam logic CFG_SEL_KEY  = 1'b0;
    localparam logic CFG_SEL_MODE = 1'b1;

endpackage

// File: rtl/pxkey_cfg_regs.sv
module pxkey_cfg_regs
    import pxkey_pkg::*;
#(
    parameter int unsigned PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [PIX_W-1:0] cfg_wdata,
    output key_mode_e        mode_o,
    output logic [PIX_W-1:0] key_o
);

    key_mode_e        mode_q;
    logic [PIX_W-1:0] key_q;

    // Key color register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q <= '0;
        end else if (cfg_we && (cfg_sel == CFG_SEL_KEY)) begin
            key_q <= cfg_wdata;
        end
    end

    // Mode register, low two bits of the write data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= KEY_NONE;
        end else if (cfg_we && (cfg_sel == CFG_SEL_MODE)) begin
            mode_q <= key_mode_e'(cfg_wdata[1:0]);
        end
    end

    assign mode_o = mode_q;
    assign key_o  = key_q;

endmodule

// File: rtl/pxkey_decide.sv
module pxkey_decide
    import pxkey_pkg::*;
#(
    parameter int unsigned PIX_W = 8
) (
    input  key_mode_e        mode,
    input  logic [PIX_W-1:0] key,
    input  logic [PIX_W-1:0] src,
    input  logic [PIX_W-1:0] dst,
    input  logic [PIX_W-1:0] res,
    output logic             keep
);

    logic res_is_zero;
    logic src_hit;
    logic dst_hit;

    assign res_is_zero = (res == '0);
    assign src_hit     = (src == key);
    assign dst_hit     = (dst == key);

    always_comb begin
        unique case (mode)
            KEY_NONE:     keep = 1'b1;
            KEY_RES_ZERO: keep = !res_is_zero;
            KEY_SRC:      keep = !src_hit;
            KEY_DST:      keep = !dst_hit;
            default:      keep = 1'b1;
        endcase
    end

endmodule

// File: rtl/pxkey_pipe.sv
module pxkey_pipe
    import pxkey_pkg::*;
#(
    parameter int unsigned PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PIX_W-1:0] in_data,
    input  logic             in_keep,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PIX_W-1:0] out_data,
    output logic             out_we
);

    slot_state_e      state_q;
    slot_state_e      state_d;
    logic             accept;
    logic [PIX_W-1:0] data_q;
    logic             we_q;

    assign in_ready = (state_q == SLOT_EMPTY) || out_ready;
    assign accept   = in_valid && in_ready;

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: state_d = accept ? SLOT_FULL : SLOT_EMPTY;
            SLOT_FULL: begin
                if (accept)         state_d = SLOT_FULL;   // fill-while-drain
                else if (out_ready) state_d = SLOT_EMPTY;  // drain
                else                state_d = SLOT_FULL;   // stall
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            we_q   <= 1'b0;
        end else if (accept) begin
            data_q <= in_data;
            we_q   <= in_keep;
        end
    end

    assign out_valid = (state_q == SLOT_FULL);
    assign out_data  = data_q;
    assign out_we    = we_q;

endmodule

// File: rtl/pxkey_mask_unit.sv
module pxkey_mask_unit
    import pxkey_pkg::*;
#(
    parameter int unsigned PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [PIX_W-1:0] cfg_wdata,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PIX_W-1:0] in_src,
    input  logic [PIX_W-1:0] in_dst,
    input  logic [PIX_W-1:0] in_res,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PIX_W-1:0] out_data,
    output logic             out_we
);

    key_mode_e        mode_q;
    logic [PIX_W-1:0] key_q;
    logic             keep;

    pxkey_cfg_regs #(.PIX_W(PIX_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .mode_o    (mode_q),
        .key_o     (key_q)
    );

    pxkey_decide #(.PIX_W(PIX_W)) u_decide (
        .mode (mode_q),
        .key  (key_q),
        .src  (in_src),
        .dst  (in_dst),
        .res  (in_res),
        .keep (keep)
    );

    pxkey_pipe #(.PIX_W(PIX_W)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_res),
        .in_keep   (keep),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_we    (out_we)
    );

endmodule

// File: rtl/pxkey_mask_checker.sv
module pxkey_mask_checker #(
    parameter int unsigned PIX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [PIX_W-1:0] in_src,
    input logic [PIX_W-1:0] in_dst,
    input logic [PIX_W-1:0] in_res,
    input logic             out_valid,
    input logic             out_ready,
    input logic [PIX_W-1:0] out_data,
    input logic             out_we,
    input logic [1:0]       cur_mode,
    input logic [PIX_W-1:0] cur_key
);

    logic acc;
    assign acc = in_valid && in_ready;

    assert_ready_rule_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == (!out_valid || out_ready));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_we)));

    assert_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (out_valid && out_data == $past(in_res)));

    assert_none_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cur_mode == 2'b00) |=> out_we);

    assert_reszero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cur_mode == 2'b01) |=> (out_we == ($past(in_res) != '0)));

    assert_srckey_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cur_mode == 2'b10) |=> (out_we == ($past(in_src) != $past(cur_key))));

    assert_dstkey_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cur_mode == 2'b11) |=> (out_we == ($past(in_dst) != $past(cur_key))));

    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && !acc) |=> !out_valid);

endmodule

bind pxkey_mask_unit pxkey_mask_checker #(.PIX_W(PIX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_src    (in_src),
    .in_dst    (in_dst),
    .in_res    (in_res),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_we    (out_we),
    .cur_mode  (mode_q),
    .cur_key   (key_q)
);

// File: tb/pxkey_mask_unit_tb.sv
module pxkey_mask_unit_tb;

    localparam int unsigned PIX_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic             cfg_sel = 1'b0;
    logic [PIX_W-1:0] cfg_wdata = '0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [PIX_W-1:0] in_src = '0;
    logic [PIX_W-1:0] in_dst = '0;
    logic [PIX_W-1:0] in_res = '0;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic [PIX_W-1:0] out_data;
    logic             out_we;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    pxkey_mask_unit #(.PIX_W(PIX_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_src    (in_src),
        .in_dst    (in_dst),
        .in_res    (in_res),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_we    (out_we)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic sel, input logic [PIX_W-1:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Send one pixel with out_ready high and check the beat one edge later
    task automatic send_px(input string req, input logic [PIX_W-1:0] s,
                           input logic [PIX_W-1:0] d, input logic [PIX_W-1:0] r,
                           input logic exp_we);
        @(negedge clk);
        out_ready = 1'b1;
        in_valid = 1'b1; in_src = s; in_dst = d; in_res = r;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, {31'b0, out_valid}, 32'd1);
        check(req, {31'b0, out_we}, {31'b0, exp_we});
        check(req, {24'b0, out_data}, {24'b0, r});
    endtask

    task automatic t_reset;
        check("R1 out_valid", {31'b0, out_valid}, 32'd0);
        check("R1 in_ready", {31'b0, in_ready}, 32'd1);
        send_px("R1 default mode none", 8'h11, 8'h22, 8'h00, 1'b1);
        write_reg(1'b1, 8'h02);                  // source key, key still 0
        send_px("R1 key resets to 0", 8'h00, 8'h05, 8'h33, 1'b0);
        write_reg(1'b1, 8'h00);
    endtask

    task automatic t_none;
        write_reg(1'b1, 8'h00);
        write_reg(1'b0, 8'h5A);
        send_px("R2 zero result", 8'h5A, 8'h5A, 8'h00, 1'b1);
        send_px("R2 key match", 8'h5A, 8'h5A, 8'hFF, 1'b1);
    endtask

    task automatic t_reszero;
        write_reg(1'b1, 8'h01);
        send_px("R3 zero hidden", 8'h10, 8'h20, 8'h00, 1'b0);
        send_px("R3 nonzero kept", 8'h10, 8'h20, 8'h01, 1'b1);
        send_px("R8 hidden beat", 8'h00, 8'h00, 8'h00, 1'b0);
    endtask

    task automatic t_srckey;
        write_reg(1'b0, 8'hC3);
        write_reg(1'b1, 8'h02);
        send_px("R4 src match", 8'hC3, 8'h00, 8'h44, 1'b0);
        send_px("R4 src differs", 8'hC2, 8'hC3, 8'h44, 1'b1);
        send_px("R4 zero res kept", 8'h00, 8'hC3, 8'h00, 1'b1);
    endtask

    task automatic t_dstkey;
        write_reg(1'b0, 8'h7E);
        write_reg(1'b1, 8'h03);
        send_px("R5 dst match", 8'h00, 8'h7E, 8'h99, 1'b0);
        send_px("R5 dst differs", 8'h7E, 8'h7F, 8'h99, 1'b1);
    endtask

    task automatic t_sel;
        write_reg(1'b0, 8'hFD);                  // R10: upper bits land in key
        write_reg(1'b1, 8'hFE);                  // R10: mode from low bits -> 10
        send_px("R10 mode from low bits", 8'hFD, 8'h00, 8'h12, 1'b0);
        send_px("R10 key full width", 8'hFC, 8'h00, 8'h12, 1'b1);
    endtask

    task automatic t_same_edge;
        write_reg(1'b1, 8'h00);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 8'h01;
        in_valid = 1'b1; in_src = 8'h00; in_dst = 8'h00; in_res = 8'h00;
        @(negedge clk);
        cfg_we = 1'b0; in_valid = 1'b0;
        check("R9 same edge old mode", {31'b0, out_we}, 32'd1);
        send_px("R9 next pixel new mode", 8'h00, 8'h00, 8'h00, 1'b0);
    endtask

    task automatic t_backpressure;
        write_reg(1'b1, 8'h00);
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1; in_res = 8'hA1;
        @(negedge clk);
        in_res = 8'hB2;                          // second pixel waits
        check("R7 ready low when full", {31'b0, in_ready}, 32'd0);
        check("R6 first beat", {24'b0, out_data}, 32'hA1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R7 hold data", {24'b0, out_data}, 32'hA1);
            check("R7 hold valid", {31'b0, out_valid}, 32'd1);
        end
        out_ready = 1'b1;
        #0;
        check("R7 ready follows out_ready", {31'b0, in_ready}, 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 queued pixel", {24'b0, out_data}, 32'hB2);
        check("R7 queued valid", {31'b0, out_valid}, 32'd1);
        @(negedge clk);
        check("R7 drained", {31'b0, out_valid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_none();
        t_reszero();
        t_srckey();
        t_dstkey();
        t_sel();
        t_same_edge();
        t_backpressure();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule